// File: doc/BRIEF.md
# Peak Window Capture Engine

The engine watches one sweep of count samples. Each sample carries its energy step, deflector step and anode number. Every sample is written into a sweep buffer. While the sweep runs, the engine tracks the largest count among the samples that pass the search filter. A sample passes when its energy and deflector steps lie inside the commanded limits and its anode is enabled in the anode mask. When the sweep's final sample arrives, the engine publishes the energy, deflector and anode indices of the winning sample.

On request the engine plays back part of the stored sweep, much as a logic analyzer shows a trigger window. It reads the peak anode's counts over a rectangle of energy and deflector steps centred on the peak. The half-widths of the rectangle are programmable. The rectangle is moved, not cut, so that it stays within the commanded limits. A request that arrives during a sweep waits until that sweep has ended.

Top module: `peak_window_capture`

## Requirements
- R1: After reset `out_valid` and `out_last` are low and `pk_e`, `pk_d` and `pk_a` are all zero.
- R2: Every sample with `smp_e < NE`, `smp_d < ND` and `smp_a < NA` is stored. A readout beat returns the count last stored for that energy step, deflector step and peak anode.
- R3: A sample is a peak candidate only when `e_lo <= smp_e <= e_hi`, `d_lo <= smp_d <= d_hi` and bit `smp_a` of `anode_mask` is 1. Other samples never become the peak, whatever their count.
- R4: Among candidates with equal maximum count, the one that arrived first in the sweep is the peak.
- R5: The peak outputs change only in the cycle after a sample with `smp_last` high. A sweep with no candidate leaves them unchanged.
- R6: A readout emits the peak anode's counts for energies `pk_e-e_off .. pk_e+e_off` and deflectors `pk_d-d_off .. pk_d+d_off`. Energy is the outer loop and deflector the inner loop, both ascending. Each beat is marked by `out_valid` and reports its indices on `out_e` and `out_d`. `out_last` marks the final beat.
- R7: If the window would cross a limit, it is shifted inside while keeping its length `2*off+1`. The upper limits in effect are `min(e_hi, NE-1)` and `min(d_hi, ND-1)`.
- R8: When `2*off` is greater than or equal to the effective upper limit minus the lower limit, that axis's window is the whole range from the lower to the effective upper limit.
- R9: A `rd_req` pulse during a sweep is held. The readout begins only after the sweep's last sample, and no beat appears while the sweep is running.
- R10: The beats of a readout come on consecutive cycles. A `rd_req` during a readout is queued and produces a second readout, which starts after at least one idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Sample present this cycle |
| smp_last | input | 1 | Final sample of the sweep |
| smp_cnt | input | CW | Sample count |
| smp_e | input | EW | Sample energy step |
| smp_d | input | DW | Sample deflector step |
| smp_a | input | AW | Sample anode |
| e_lo | input | EW | Lower energy limit |
| e_hi | input | EW | Upper energy limit |
| d_lo | input | DW | Lower deflector limit |
| d_hi | input | DW | Upper deflector limit |
| anode_mask | input | NA | Anodes that take part in the search |
| e_off | input | EOW | Energy half-width of the window |
| d_off | input | DOW | Deflector half-width of the window |
| rd_req | input | 1 | Readout request pulse |
| out_valid | output | 1 | Readout beat valid |
| out_last | output | 1 | Final beat of a readout |
| out_cnt | output | CW | Readout count |
| out_e | output | EW | Readout energy step |
| out_d | output | DW | Readout deflector step |
| pk_e | output | EW | Energy step of the latest peak |
| pk_d | output | DW | Deflector step of the latest peak |
| pk_a | output | AW | Anode of the latest peak |

## Verification
Each sweep plants a large decoy on a masked anode, and some sweeps plant a second decoy outside the energy limits, so that a filter that leaks is reported as a wrong peak. Across the sweeps the peak is placed in the interior, against a lower limit, against an upper limit and beyond the buffer's own upper edge. Some offsets exceed the range, which separates shifting from truncation and from whole-range fallback. A sweep with a tied pair checks arrival-order priority. A fully masked sweep checks that the peak outputs are kept. A request made in the middle of every sweep, and a second request made during a readout, check the holding and queuing of requests.

// File: rtl/peak_window_capture.sv
module peak_window_capture #(
  parameter int CW  = 16,
  parameter int NE  = 16,
  parameter int ND  = 4,
  parameter int NA  = 24,
  parameter int EW  = 7,
  parameter int DW  = 5,
  parameter int AW  = 5,
  parameter int EOW = 6,
  parameter int DOW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           smp_valid,
  input  logic           smp_last,
  input  logic [CW-1:0]  smp_cnt,
  input  logic [EW-1:0]  smp_e,
  input  logic [DW-1:0]  smp_d,
  input  logic [AW-1:0]  smp_a,
  input  logic [EW-1:0]  e_lo,
  input  logic [EW-1:0]  e_hi,
  input  logic [DW-1:0]  d_lo,
  input  logic [DW-1:0]  d_hi,
  input  logic [NA-1:0]  anode_mask,
  input  logic [EOW-1:0] e_off,
  input  logic [DOW-1:0] d_off,
  input  logic           rd_req,
  output logic           out_valid,
  output logic           out_last,
  output logic [CW-1:0]  out_cnt,
  output logic [EW-1:0]  out_e,
  output logic [DW-1:0]  out_d,
  output logic [EW-1:0]  pk_e,
  output logic [DW-1:0]  pk_d,
  output logic [AW-1:0]  pk_a
);
  localparam int DEPTH = NE * ND * NA;
  localparam int MW    = $clog2(DEPTH);

  function automatic logic [MW-1:0] addr(input logic [EW-1:0] e, input logic [DW-1:0] d,
                                         input logic [AW-1:0] a);
    return MW'((int'(e) * ND + int'(d)) * NA + int'(a));
  endfunction

  function automatic int win_lo(input int p, input int lo, input int hi, input int off, input int lim);
    int u;
    u = (hi > lim - 1) ? lim - 1 : hi;
    if (2 * off >= u - lo) return lo;
    if (p < lo + off)      return lo;
    if (p + off > u)       return u - 2 * off;
    return p - off;
  endfunction

  function automatic int win_hi(input int start, input int lo, input int hi, input int off, input int lim);
    int u;
    u = (hi > lim - 1) ? lim - 1 : hi;
    if (2 * off >= u - lo) return u;
    return start + 2 * off;
  endfunction

  logic [CW-1:0] mem [DEPTH];

  logic          srch, have;
  logic [CW-1:0] best;
  logic [EW-1:0] be;
  logic [DW-1:0] bd;
  logic [AW-1:0] ba;

  wire in_buf = int'(smp_e) < NE && int'(smp_d) < ND && int'(smp_a) < NA;
  wire qual   = smp_valid && in_buf && smp_e >= e_lo && smp_e <= e_hi &&
                smp_d >= d_lo && smp_d <= d_hi && anode_mask[smp_a];
  wire fresh  = !srch;
  wire take   = qual && (fresh || !have || smp_cnt > best);

  always_ff @(posedge clk)
    if (smp_valid && in_buf) mem[addr(smp_e, smp_d, smp_a)] <= smp_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srch <= 1'b0; have <= 1'b0; best <= '0;
      be <= '0; bd <= '0; ba <= '0;
      pk_e <= '0; pk_d <= '0; pk_a <= '0;
    end else if (smp_valid) begin
      srch <= !smp_last;
      have <= take | (have & !fresh);
      if (take) begin
        best <= smp_cnt; be <= smp_e; bd <= smp_d; ba <= smp_a;
      end
      if (smp_last) begin
        if (take) begin
          pk_e <= smp_e; pk_d <= smp_d; pk_a <= smp_a;
        end else if (have && !fresh) begin
          pk_e <= be; pk_d <= bd; pk_a <= ba;
        end
      end
    end
  end

  logic          rd_act, pend;
  logic [EW-1:0] ce, we;
  logic [DW-1:0] cd, ds, de;
  logic [AW-1:0] ra;

  wire rd_go = (pend | rd_req) && !rd_act && !srch && !smp_valid;
  int  es_n, ds_n;
  always_comb begin
    es_n = win_lo(int'(pk_e), int'(e_lo), int'(e_hi), int'(e_off), NE);
    ds_n = win_lo(int'(pk_d), int'(d_lo), int'(d_hi), int'(d_off), ND);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_act <= 1'b0; pend <= 1'b0;
      ce <= '0; we <= '0; cd <= '0; ds <= '0; de <= '0; ra <= '0;
      out_valid <= 1'b0; out_last <= 1'b0; out_cnt <= '0; out_e <= '0; out_d <= '0;
    end else begin
      pend <= (pend | rd_req) & !rd_go;
      out_valid <= rd_act;
      out_last  <= rd_act && ce == we && cd == de;
      if (rd_go) begin
        rd_act <= 1'b1;
        ce <= EW'(es_n);
        we <= EW'(win_hi(es_n, int'(e_lo), int'(e_hi), int'(e_off), NE));
        cd <= DW'(ds_n);
        ds <= DW'(ds_n);
        de <= DW'(win_hi(ds_n, int'(d_lo), int'(d_hi), int'(d_off), ND));
        ra <= pk_a;
      end else if (rd_act) begin
        out_cnt <= mem[addr(ce, cd, ra)];
        out_e   <= ce;
        out_d   <= cd;
        if (cd == de) begin
          cd <= ds;
          if (ce == we) rd_act <= 1'b0;
          else          ce <= ce + 1'b1;
        end else begin
          cd <= cd + 1'b1;
        end
      end
    end
  end

  // R9
  rd_idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_act) |-> !$past(srch));
  // R10
  burst_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_valid);
  // R10
  burst_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |=> out_valid);
  // R7
  in_buffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_e) < NE && int'(out_d) < ND));
  // R5
  peak_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_valid && smp_last) |=> $stable(pk_e) && $stable(pk_d) && $stable(pk_a));
endmodule

// File: tb/peak_window_capture_bench.sv
module peak_window_capture_bench;
  localparam int NE = 16, ND = 4, NA = 24;
  localparam logic [23:0] MASK = 24'hFFFF7F;

  typedef struct packed {
    logic [6:0] elo, ehi;
    logic [4:0] dlo, dhi;
    logic [5:0] eo;
    logic [3:0] dof;
    logic [6:0] pe;
    logic [4:0] pd, pa;
    logic       xen;
    logic [6:0] xe;
    logic       ten;
    logic [6:0] te;
    logic [4:0] td, ta;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{7'd0, 7'd15, 5'd0, 5'd3, 6'd2, 4'd1, 7'd8,  5'd2, 5'd5,  1'b0, 7'd0,  1'b0, 7'd0, 5'd0, 5'd0},
    '{7'd0, 7'd15, 5'd0, 5'd3, 6'd3, 4'd1, 7'd1,  5'd0, 5'd3,  1'b0, 7'd0,  1'b0, 7'd0, 5'd0, 5'd0},
    '{7'd2, 7'd12, 5'd0, 5'd3, 6'd2, 4'd0, 7'd12, 5'd3, 5'd20, 1'b1, 7'd14, 1'b0, 7'd0, 5'd0, 5'd0},
    '{7'd0, 7'd31, 5'd0, 5'd3, 6'd2, 4'd1, 7'd15, 5'd3, 5'd23, 1'b0, 7'd0,  1'b0, 7'd0, 5'd0, 5'd0},
    '{7'd4, 7'd9,  5'd1, 5'd2, 6'd5, 4'd3, 7'd6,  5'd1, 5'd0,  1'b1, 7'd2,  1'b0, 7'd0, 5'd0, 5'd0},
    '{7'd0, 7'd15, 5'd0, 5'd3, 6'd4, 4'd2, 7'd7,  5'd1, 5'd9,  1'b0, 7'd0,  1'b0, 7'd0, 5'd0, 5'd0},
    '{7'd0, 7'd15, 5'd0, 5'd3, 6'd1, 4'd1, 7'd3,  5'd1, 5'd2,  1'b0, 7'd0,  1'b1, 7'd9, 5'd2, 5'd4}
  };
  localparam string VTAG [NV] = '{"R6", "R7", "R7", "R7", "R8", "R8", "R6"};

  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_valid = 1'b0, smp_last = 1'b0, rd_req = 1'b0;
  logic [15:0] smp_cnt = '0;
  logic [6:0] smp_e = '0, e_lo = '0, e_hi = '0;
  logic [4:0] smp_d = '0, smp_a = '0, d_lo = '0, d_hi = '0;
  logic [23:0] anode_mask = '0;
  logic [5:0] e_off = '0;
  logic [3:0] d_off = '0;
  logic out_valid, out_last;
  logic [15:0] out_cnt;
  logic [6:0] out_e, pk_e;
  logic [4:0] out_d, pk_d, pk_a;

  peak_window_capture u_peak_window_capture (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_last(smp_last),
    .smp_cnt(smp_cnt), .smp_e(smp_e), .smp_d(smp_d), .smp_a(smp_a),
    .e_lo(e_lo), .e_hi(e_hi), .d_lo(d_lo), .d_hi(d_hi), .anode_mask(anode_mask),
    .e_off(e_off), .d_off(d_off), .rd_req(rd_req), .out_valid(out_valid),
    .out_last(out_last), .out_cnt(out_cnt), .out_e(out_e), .out_d(out_d),
    .pk_e(pk_e), .pk_d(pk_d), .pk_a(pk_a));

  always #2 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  int ncap = 0, nlast = 0, early = 0;
  bit in_sweep = 1'b0;
  int dat [NE][ND][NA];
  int cap_e [256], cap_d [256], cap_c [256], cap_t [256];
  int xp_e = 0, xp_d = 0, xp_a = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (out_valid) begin
      if (in_sweep) early++;
      if (ncap < 256) begin
        cap_e[ncap] = int'(out_e); cap_d[ncap] = int'(out_d);
        cap_c[ncap] = int'(out_cnt); cap_t[ncap] = cyc;
      end
      ncap++;
      if (out_last) nlast++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int wlo(input int p, input int lo, input int hi, input int off, input int lim);
    int u = (hi > lim - 1) ? lim - 1 : hi;
    if (2 * off >= u - lo) return lo;
    if (p < lo + off) return lo;
    if (p + off > u) return u - 2 * off;
    return p - off;
  endfunction

  function automatic int whi(input int s, input int lo, input int hi, input int off, input int lim);
    int u = (hi > lim - 1) ? lim - 1 : hi;
    if (2 * off >= u - lo) return u;
    return s + 2 * off;
  endfunction

  task automatic fill(input vec_t v);
    for (int e = 0; e < NE; e++)
      for (int d = 0; d < ND; d++)
        for (int a = 0; a < NA; a++)
          dat[e][d][a] = (e * 5 + d * 11 + a * 3) % 97 + 1;
    dat[0][0][7] = 3000;
    dat[v.pe][v.pd][v.pa] = 1000;
    if (v.xen) dat[v.xe][v.dlo][0] = 3000;
    if (v.ten) dat[v.te][v.td][v.ta] = 1000;
  endtask

  task automatic sweep(input vec_t v, input logic [23:0] m, input bit rq);
    int idx = 0, best = -1;
    int ne = xp_e, nd = xp_d, na = xp_a;
    e_lo = v.elo; e_hi = v.ehi; d_lo = v.dlo; d_hi = v.dhi;
    e_off = v.eo; d_off = v.dof; anode_mask = m;
    for (int e = 0; e < NE; e++)
      for (int d = 0; d < ND; d++)
        for (int a = 0; a < NA; a++) begin
          if (e >= int'(v.elo) && e <= int'(v.ehi) && d >= int'(v.dlo) && d <= int'(v.dhi)
              && m[a] && dat[e][d][a] > best) begin
            best = dat[e][d][a]; ne = e; nd = d; na = a;
          end
          @(negedge clk);
          in_sweep = 1'b1;
          if (idx == NE * ND * NA - 1) // R5 no change before the last sample
            chk(pk_e == 7'(xp_e) && pk_d == 5'(xp_d) && pk_a == 5'(xp_a), "R5 hold", int'(pk_e), xp_e);
          smp_valid = 1'b1; smp_cnt = 16'(dat[e][d][a]);
          smp_e = 7'(e); smp_d = 5'(d); smp_a = 5'(a);
          smp_last = (idx == NE * ND * NA - 1);
          rd_req = rq && idx == 100;
          idx++;
        end
    @(negedge clk);
    smp_valid = 1'b0; smp_last = 1'b0; rd_req = 1'b0; in_sweep = 1'b0;
    xp_e = ne; xp_d = nd; xp_a = na;
    chk(pk_e == 7'(xp_e), "R3 R4 R5 peak energy", int'(pk_e), xp_e);
    chk(pk_d == 5'(xp_d), "R3 R4 R5 peak deflector", int'(pk_d), xp_d);
    chk(pk_a == 5'(xp_a), "R3 R4 R5 peak anode", int'(pk_a), xp_a);
  endtask

  task automatic wait_last(input int want);
    int t = 0;
    while (nlast < want && t < 5000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic check_burst(input vec_t v, input string tag, input int base);
    int es = wlo(xp_e, int'(v.elo), int'(v.ehi), int'(v.eo), NE);
    int ee = whi(es, int'(v.elo), int'(v.ehi), int'(v.eo), NE);
    int ds = wlo(xp_d, int'(v.dlo), int'(v.dhi), int'(v.dof), ND);
    int de = whi(ds, int'(v.dlo), int'(v.dhi), int'(v.dof), ND);
    int dn = de - ds + 1;
    int n = (ee - es + 1) * dn;
    chk(ncap - base >= n, {tag, " beat count"}, ncap - base, n);
    for (int i = 0; i < n && base + i < 256; i++) begin
      int e = es + i / dn, d = ds + i % dn;
      chk(cap_e[base + i] == e, {tag, " energy index"}, cap_e[base + i], e);
      chk(cap_d[base + i] == d, {tag, " deflector index"}, cap_d[base + i], d);
      chk(cap_c[base + i] == dat[e][d][xp_a], "R2 stored count", cap_c[base + i], dat[e][d][xp_a]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL R9 watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0 && out_last == 1'b0, "R1 outputs idle", int'(out_valid), 0);
    chk(pk_e == '0 && pk_d == '0 && pk_a == '0, "R1 peak zero", int'(pk_e), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int vi = 0; vi < NV; vi++) begin
      fill(VECS[vi]);
      ncap = 0; nlast = 0; early = 0;
      sweep(VECS[vi], MASK, 1'b1);
      chk(early == 0, "R9 no beat during sweep", early, 0);
      wait_last(1);
      chk(nlast == 1, "R9 held request served", nlast, 1);
      check_burst(VECS[vi], VTAG[vi], 0);
    end

    // R10 request during a readout is queued
    ncap = 0; nlast = 0;
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    while (ncap < 3) @(negedge clk);
    rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    wait_last(2);
    chk(nlast == 2, "R10 second readout", nlast, 2);
    chk(ncap == 18, "R10 beat total", ncap, 18);
    chk(cap_t[9] - cap_t[8] >= 2, "R10 idle gap", cap_t[9] - cap_t[8], 2);
    check_burst(VECS[NV - 1], "R10", 9);

    // R5 R3 sweep with every anode masked keeps the peak
    ncap = 0; nlast = 0;
    fill(VECS[0]);
    sweep(VECS[0], 24'h000000, 1'b0);
    repeat (4) @(negedge clk);
    chk(pk_e == 7'd3 && pk_d == 5'd1 && pk_a == 5'd2, "R5 empty sweep keeps peak", int'(pk_e), 3);
    chk(ncap == 0, "R9 no readout without request", ncap, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule